// File: doc/BRIEF.md
# Single-Shot Multi-Channel ADC Conversion Sequencer

This block is the digital control around a multi-channel analog-to-digital converter used in a software-triggered, one-conversion-per-trigger mode. Software programs a channel mask and then writes a control word with the run bit set. The sequencer picks one channel from the mask and starts a fixed-latency conversion engine. When the engine returns a value, the sequencer stores it in the result register that belongs to that channel, drops its busy flag and gives a one-cycle end-of-conversion interrupt.

The run bit stays set after a conversion ends, but the converter stays idle until software writes a 1 to it again. Any write to the control word while a conversion is running abandons that conversion. If the new word has the run bit set, a fresh conversion starts from its first cycle. The conversion engine here is a behavioural stand-in with a parameterised latency. It returns a value built from the channel number and a count of the conversions started so far.

Register map (word addresses on `wrAddr`/`rdAddr`): 0 is the control word (bit 0 run bit, read/write; bit 1 busy, read-only), 1 is the channel mask (bits 0 to NUM_CH-1), and 8+k is the result of channel k, zero-extended.

Top module: `adc_oneshot_seq`

## Requirements
- R1: After a synchronous active-high reset, every result register, the mask and the control word read 0, and `busy` and `eocIrq` are 0.
- R2: Writing address 0 with bit 0 = 1 while the mask is nonzero starts a conversion: `busy` is 1 from the next cycle and stays 1 for exactly CONV_LAT cycles (default 16).
- R3: The converted channel is the lowest-numbered set bit of the mask; a mask of 0x0004 converts channel 2. Mask bits at or above NUM_CH are not stored and read back as 0.
- R4: On completion only the result register of the converted channel (address 8+k) changes. It gets the value (k << 8) | t, where t is the number of conversions started since reset before this one, modulo 256. The other result registers keep their values.
- R5: `eocIrq` is a one-cycle pulse. It is high in the first cycle in which `busy` is 0 and the new result is readable, which is CONV_LAT+1 cycles after the cycle the start write was presented.
- R6: After completion the control word reads 1 (run bit still set, busy clear). No further conversion or interrupt occurs until address 0 is written with bit 0 = 1 again.
- R7: A write to address 0 while `busy` is 1 abandons the running conversion, even in its final cycle: there is no result write and no interrupt for it. If the written bit 0 is 1 and the mask is nonzero, a new conversion starts with the full latency. If bit 0 is 0, the block goes idle.
- R8: With a mask of 0, writing bit 0 = 1 starts nothing. `busy` stays 0 and no interrupt occurs, but the control word reads 1.
- R9: Writing the mask during a conversion does not change which channel that conversion stores into.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address (combinational read) |
| rdData | output | 16 | Register read data |
| busy | output | 1 | Conversion in progress |
| eocIrq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench aims at the abort paths. A control write in mid-conversion, one in the very last cycle of a conversion, and one that clears the run bit must each suppress the pending result and interrupt. A design that lets the final-cycle completion win would raise an interrupt early and store a stale value. It also checks that the run bit left at 1 does not re-trigger, which would show up as stray interrupts. Masks with several bits set, and with only out-of-range bits, are used to catch a wrong priority pick or a zero-mask start. A mask rewrite during a conversion is used to catch a channel that is not latched at start. Each interrupt is checked against its predicted cycle, channel and tag value, which counts restarted conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W    = 4;
  localparam int REG_W     = 16;
  localparam int CTRL_ADDR = 0;
  localparam int MASK_ADDR = 1;
  localparam int RES_BASE  = 8;
  localparam int CHF_W     = 4;

  typedef enum logic {SEQ_IDLE, SEQ_CONV} seqState_t;

  typedef struct packed {
    logic startConv;
    logic abortConv;
    logic commit;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrCtrl,
  input  logic       wrRunBit,
  input  logic       maskAny,
  input  logic       engDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       runBit,
  output logic       eocIrq
);
  seqState_t stateQ;
  logic      runQ;
  logic      irqQ;
  logic      convActive;

  assign convActive       = (stateQ == SEQ_CONV);
  assign strobe.startConv = wrCtrl && wrRunBit && maskAny;
  assign strobe.abortConv = wrCtrl && convActive;
  assign strobe.commit    = engDone && convActive && !wrCtrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= SEQ_IDLE;
      runQ   <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (wrCtrl) runQ <= wrRunBit;
      if (strobe.startConv)                        stateQ <= SEQ_CONV;
      else if (strobe.abortConv || strobe.commit)  stateQ <= SEQ_IDLE;
      irqQ <= strobe.commit;
    end
  end

  assign busy   = convActive;
  assign runBit = runQ;
  assign eocIrq = irqQ;

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    eocIrq |=> !eocIrq);
  assert_irq_idle_R5: assert property (@(posedge clk) disable iff (rst)
    eocIrq |-> !busy);
  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(wrCtrl) |-> !eocIrq);
  assert_busy_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(engDone) || $past(wrCtrl)));
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int RES_W  = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrMask,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  seqStrobe_t        strobe,
  input  logic [RES_W-1:0]  engResult,
  input  logic              busy,
  input  logic              runBit,
  output logic              maskAny,
  output logic [CH_W-1:0]   pickChan,
  output logic [REG_W-1:0]  rdData
);
  logic [NUM_CH-1:0] maskQ;
  logic [CH_W-1:0]   chanQ;
  logic [RES_W-1:0]  resQ [NUM_CH];
  logic [NUM_CH-1:0] hitCh;

  always_ff @(posedge clk) begin
    if (rst) maskQ <= '0;
    else if (wrMask) maskQ <= wrData[NUM_CH-1:0];
  end

  always_comb begin
    pickChan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (maskQ[i]) pickChan = CH_W'(i);
    end
  end
  assign maskAny = |maskQ;

  always_ff @(posedge clk) begin
    if (rst) chanQ <= '0;
    else if (strobe.startConv) chanQ <= pickChan;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_res
    assign hitCh[k] = strobe.commit && (chanQ == CH_W'(k));
    always_ff @(posedge clk) begin
      if (rst) resQ[k] <= '0;
      else if (hitCh[k]) resQ[k] <= engResult;
    end
    assert_res_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(hitCh[k]) |-> $stable(resQ[k]));
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(CTRL_ADDR)) begin
      rdData = {{(REG_W-2){1'b0}}, busy, runBit};
    end else if (rdAddr == ADDR_W'(MASK_ADDR)) begin
      rdData = REG_W'(maskQ);
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (rdAddr == ADDR_W'(RES_BASE + k)) rdData = REG_W'(resQ[k]);
      end
    end
  end

  assert_chan_latched_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.startConv) |-> $stable(chanQ));
  assert_commit_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitCh));
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int RES_W    = 12,
  parameter int CONV_LAT = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W   = $clog2(CONV_LAT + 1),
  localparam int TAG_W   = RES_W - CHF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [CH_W-1:0]  chanIn,
  output logic             done,
  output logic [RES_W-1:0] result
);
  logic             activeQ;
  logic [CNT_W-1:0] cntQ;
  logic [CH_W-1:0]  chanQ;
  logic [TAG_W-1:0] tagQ;
  logic [TAG_W-1:0] startCntQ;
  logic [CNT_W-1:0] elapsedQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ   <= 1'b0;
      cntQ      <= '0;
      chanQ     <= '0;
      tagQ      <= '0;
      startCntQ <= '0;
    end else if (strobe.startConv) begin
      activeQ   <= 1'b1;
      cntQ      <= CNT_W'(CONV_LAT);
      chanQ     <= chanIn;
      tagQ      <= startCntQ;
      startCntQ <= startCntQ + 1'b1;
    end else if (strobe.abortConv) begin
      activeQ <= 1'b0;
    end else if (activeQ) begin
      if (cntQ == CNT_W'(1)) activeQ <= 1'b0;
      else cntQ <= cntQ - 1'b1;
    end
  end

  assign done   = activeQ && (cntQ == CNT_W'(1));
  assign result = {CHF_W'(chanQ), tagQ};

  always_ff @(posedge clk) begin
    if (rst || strobe.startConv) elapsedQ <= '0;
    else if (activeQ) elapsedQ <= elapsedQ + 1'b1;
  end

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (elapsedQ == CNT_W'(CONV_LAT - 1)));
endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int RES_W    = 12,
  parameter int CONV_LAT = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              busy,
  output logic              eocIrq
);
  seqStrobe_t       strobe;
  logic             wrCtrl;
  logic             wrMask;
  logic             maskAny;
  logic             engDone;
  logic             runBit;
  logic [CH_W-1:0]  pickChan;
  logic [RES_W-1:0] engResult;

  assign wrCtrl = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign wrMask = wrEn && (wrAddr == ADDR_W'(MASK_ADDR));

  adc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrCtrl   (wrCtrl),
    .wrRunBit (wrData[0]),
    .maskAny  (maskAny),
    .engDone  (engDone),
    .strobe   (strobe),
    .busy     (busy),
    .runBit   (runBit),
    .eocIrq   (eocIrq)
  );

  adc_seq_dpath #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .wrMask    (wrMask),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .strobe    (strobe),
    .engResult (engResult),
    .busy      (busy),
    .runBit    (runBit),
    .maskAny   (maskAny),
    .pickChan  (pickChan),
    .rdData    (rdData)
  );

  adc_conv_stub #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CONV_LAT(CONV_LAT)) u_stub (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .chanIn (pickChan),
    .done   (engDone),
    .result (engResult)
  );
endmodule

// File: tb/adc_oneshot_seq_test.sv
module adc_oneshot_seq_test;
  localparam int LAT = 16;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr;
  logic [15:0] rdData;
  logic        busy;
  logic        eocIrq;

  logic [3:0]  drvAddr = '0;
  logic [3:0]  monAddr = '0;
  logic        monSel = 1'b0;
  assign rdAddr = monSel ? monAddr : drvAddr;

  always #2 clk = ~clk;

  adc_oneshot_seq #(.NUM_CH(NCH), .RES_W(12), .CONV_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .eocIrq(eocIrq)
  );

  typedef struct { int ch; int val; int due; } expItem_t;
  expItem_t expQ[$];

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;
  int startCnt = 0;
  int maskM = 0;
  int expRes[NCH];
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int expv);
    nChecks++;
    if (act !== expv) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int lowestBit(int m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic wrReg(int addr, int data);
    int wEdge;
    @(negedge clk);
    wEdge = cyc + 1;
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 16'(data);
    if (addr == 1) maskM = data & ((1 << NCH) - 1);
    if (addr == 0) begin
      if (expQ.size() > 0 && expQ[$].due >= wEdge) void'(expQ.pop_back());
      if (data[0] && lowestBit(maskM) >= 0) begin
        expItem_t e;
        e.ch = lowestBit(maskM);
        e.val = (e.ch << 8) | (startCnt & 255);
        e.due = wEdge + LAT;
        expQ.push_back(e);
        startCnt++;
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(int addr, output int val);
    @(negedge clk);
    drvAddr = 4'(addr);
    #1;
    val = int'(rdData);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * LAT && expQ.size() > 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Scoreboard monitor: each interrupt must match the oldest expected item.
  always @(negedge clk) begin
    if (!rst) begin
      if (eocIrq) begin
        if (expQ.size() == 0) begin
          check("R6/R7 unexpected interrupt", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check("R5 interrupt cycle", cyc, e.due);
          check("R5 busy clear with interrupt", int'(busy), 0);
          monSel = 1'b1; monAddr = 4'(8 + e.ch);
          #1;
          check("R4 result value", int'(rdData), e.val);
          monSel = 1'b0;
          expRes[e.ch] = e.val;
        end
      end else if (expQ.size() > 0 && cyc > expQ[0].due) begin
        check("R2 missing interrupt", cyc, expQ[0].due);
        void'(expQ.pop_front());
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    for (int k = 0; k < NCH; k++) expRes[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy after reset", int'(busy), 0);
    check("R1 irq after reset", int'(eocIrq), 0);
    rdReg(0, v); check("R1 control word", v, 0);
    rdReg(1, v); check("R1 mask", v, 0);
    for (int k = 0; k < NCH; k++) begin
      rdReg(8 + k, v); check("R1 result reset", v, 0);
    end

    // R2/R3 mask 0x0004 -> channel 2, busy width
    wrReg(1, 16'h0004);
    wrReg(0, 1);
    n = 0;
    for (int i = 0; i < LAT + 4; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
    check("R2 busy width", n, LAT);
    waitIdle();
    rdReg(10, v); check("R3 channel 2 result", v, (2 << 8) | 0);

    // R6 run bit stays, no re-trigger
    rdReg(0, v); check("R6 control after completion", v, 1);
    repeat (3 * LAT) @(negedge clk);
    check("R6 stays idle", int'(busy), 0);

    // R6 re-arm
    wrReg(0, 1);
    waitIdle();

    // R3 priority among several bits and masked-off high bits
    wrReg(1, 16'h0030);
    wrReg(0, 1);
    waitIdle();
    wrReg(1, 16'hFFC0);
    rdReg(1, v); check("R3 high mask bits dropped", v, 0);

    // R8 zero effective mask
    wrReg(0, 1);
    repeat (LAT + 4) @(negedge clk);
    check("R8 no busy with zero mask", int'(busy), 0);
    rdReg(0, v); check("R8 run bit stored", v, 1);

    wrReg(1, 16'h00E0);
    wrReg(0, 1);
    waitIdle();

    // R7 abort with restart in mid-conversion
    wrReg(1, 16'h0009);
    wrReg(0, 1);
    repeat (5) @(negedge clk);
    wrReg(0, 1);
    waitIdle();

    // R7 abort to idle
    wrReg(1, 16'h0002);
    wrReg(0, 1);
    repeat (4) @(negedge clk);
    wrReg(0, 0);
    check("R7 busy cleared by stop", int'(busy), 0);
    repeat (LAT + 4) @(negedge clk);
    rdReg(9, v); check("R7 no result after stop", v, expRes[1]);
    rdReg(0, v); check("R7 control after stop", v, 0);

    // R7 abort in the final cycle, with restart
    wrReg(1, 16'h0010);
    wrReg(0, 1);
    repeat (LAT - 2) @(negedge clk);
    wrReg(0, 1);
    check("R7 restart busy", int'(busy), 1);
    waitIdle();

    // R9 mask rewrite during conversion
    wrReg(1, 16'h0002);
    wrReg(0, 1);
    repeat (3) @(negedge clk);
    wrReg(1, 16'h0001);
    waitIdle();
    rdReg(8, v); check("R9 channel 0 untouched", v, expRes[0]);

    // R4 full scan of result registers
    for (int k = 0; k < NCH; k++) begin
      rdReg(8 + k, v); check("R4 result scan", v, expRes[k]);
    end
    check("R2 no pending conversion", expQ.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule